// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of address translations. A lookup presents a virtual address and the identifier of the running address space. The page-number field is compared against every stored entry at once, together with the address-space tag, and only entries marked valid take part. A hit returns the stored frame number with the untouched page offset appended, forming the physical address. Entries belonging to different address spaces can sit side by side, so a context switch does not need a flush.

A lookup whose page number is not below the page-table length input is illegal. It reports a fault and no walk is requested. A legal lookup that finds no entry reports a miss and raises a one-cycle request, carrying the page number and tag, to an external page-table walker. The walker answers on a refill port, which installs the translation. The cache can also be flushed completely, or selectively for one address-space tag. All results are registered, so a response arrives one cycle after its lookup.

Top module: `asid_tlb`

## Requirements
- R1: Every cycle with `lkValid` high produces, exactly one clock later, `rspValid` high with exactly one of `rspHit`, `rspMiss`, `rspFault`. `rspValid` stays low in the cycle after a cycle without a lookup.
- R2: A hit requires a valid entry whose page number equals `lkVaddr[31:12]` and whose tag equals `lkAsid`. On a hit, `rspPaddr` is `{frame, lkVaddr[11:0]}`.
- R3: An entry with a matching page number but a different tag does not hit. The same page number under two tags returns each tag's own frame.
- R4: A lookup with page number >= `tableLen` reports a fault, even if a matching entry exists. It raises no `walkReq`, and `rspPaddr` is 0.
- R5: A legal miss raises `walkReq` in the same cycle as `rspMiss`, with `walkVpn` and `walkAsid` equal to the looked-up page number and tag. `rspPaddr` is 0 on a miss.
- R6: A refill installs its translation, so a lookup in a later cycle hits. A lookup in the same cycle as the refill sees the contents from before the refill.
- R7: A refill of a new translation takes the lowest-index invalid entry.
- R8: When all entries are valid, a refill evicts the entry at a round-robin pointer. The pointer starts at index 0 after reset and advances by one, wrapping, after each such eviction.
- R9: A refill whose page number and tag already exist in a valid entry overwrites that entry and does not occupy a second one.
- R10: `flushAll` invalidates every entry in one cycle.
- R11: `flushAsidValid` invalidates only the entries whose tag equals `flushAsid`.
- R12: A refill presented in the same cycle as either flush is discarded.
- R13: After reset, every entry is invalid, and `rspValid` and `walkReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 32 | Virtual address: page number [31:12], offset [11:0] |
| lkAsid | input | 8 | Address-space tag of the lookup |
| tableLen | input | 21 | Page-table length; page numbers at or above it fault |
| rspValid | output | 1 | Registered response strobe |
| rspHit | output | 1 | Translation found |
| rspMiss | output | 1 | Legal lookup, not cached |
| rspFault | output | 1 | Illegal page number |
| rspPaddr | output | 32 | Physical address on a hit, else 0 |
| walkReq | output | 1 | One-cycle request to the page-table walker |
| walkVpn | output | 20 | Page number to walk |
| walkAsid | output | 8 | Tag of the walk |
| refillValid | input | 1 | Walker response: install entry |
| refillVpn | input | 20 | Page number of the installed entry |
| refillAsid | input | 8 | Tag of the installed entry |
| refillPfn | input | 20 | Frame number of the installed entry |
| flushAll | input | 1 | Invalidate every entry |
| flushAsidValid | input | 1 | Invalidate entries of one tag |
| flushAsid | input | 8 | Tag selected for a selective flush |

## Verification
The checker watches the one-cycle response timing and the single-outcome encoding on every cycle. It also checks that a hit passes the page offset through unchanged, that illegal page numbers fault without a walk request, that a walk request only accompanies a miss, and that no hit follows directly after a global flush. Which slot a refill occupies is not visible at the ports. The bench therefore shows lowest-free placement, in-place overwrite and round-robin eviction through the order in which later refills push out older translations. It also covers tag isolation, selective flushes, and refills discarded by a concurrent flush, all through scripted sequences.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Strobes the control hands to the entry storage each cycle.
  typedef struct packed {
    logic flushAll;   // clear every valid bit
    logic flushAsid;  // clear valid bits whose tag matches
    logic write;      // install refill data at writeIdx
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  writeIdx,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [ASID_W-1:0] refillAsid,
  input  logic [PFN_W-1:0]  refillPfn,
  input  logic [ASID_W-1:0] flushTag,
  input  logic [VPN_W-1:0]  lookVpn,
  input  logic [ASID_W-1:0] lookAsid,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] hitVec,
  output logic [ENTRIES-1:0] refillHitVec,
  output logic [PFN_W-1:0]  hitPfn
);
  logic [VPN_W-1:0]  vpnQ  [ENTRIES];
  logic [ASID_W-1:0] asidQ [ENTRIES];
  logic [PFN_W-1:0]  pfnQ  [ENTRIES];
  logic [ENTRIES-1:0] validQ;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic writeHere;
    assign writeHere = strobe.write && (writeIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
      end else if (strobe.flushAll) begin
        validQ[i] <= 1'b0;
      end else if (strobe.flushAsid && (asidQ[i] == flushTag)) begin
        validQ[i] <= 1'b0;
      end else if (writeHere) begin
        validQ[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (writeHere) begin
        vpnQ[i]  <= refillVpn;
        asidQ[i] <= refillAsid;
        pfnQ[i]  <= refillPfn;
      end
    end

    assign hitVec[i]       = validQ[i] && (vpnQ[i] == lookVpn) && (asidQ[i] == lookAsid);
    assign refillHitVec[i] = validQ[i] && (vpnQ[i] == refillVpn) && (asidQ[i] == refillAsid);
  end

  assign validVec = validQ;

  always_comb begin
    hitPfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitPfn = hitPfn | pfnQ[i];
    end
  end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic [OFF_W-1:0]   lkOffset,
  input  logic [VPN_W:0]     tableLen,
  input  logic               refillValid,
  input  logic               flushAll,
  input  logic               flushAsidValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [ENTRIES-1:0] refillHitVec,
  input  logic [PFN_W-1:0]   hitPfn,
  output tlbStrobe_t         strobe,
  output logic [IDX_W-1:0]   writeIdx,
  output logic               rspValid,
  output logic               rspHit,
  output logic               rspMiss,
  output logic               rspFault,
  output logic [PFN_W+OFF_W-1:0] rspPaddr,
  output logic               walkReq,
  output logic [VPN_W-1:0]   walkVpn,
  output logic [ASID_W-1:0]  walkAsid
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx, matchIdx;
  logic anyFree, anyMatch, useRr;
  logic faultNow, hitNow, missNow;

  // Victim selection: existing match, then lowest free slot, then round robin.
  always_comb begin
    freeIdx  = '0;
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i])    freeIdx  = IDX_W'(i);
      if (refillHitVec[i]) matchIdx = IDX_W'(i);
    end
    anyFree  = ~&validVec;
    anyMatch = |refillHitVec;
    useRr    = !anyMatch && !anyFree;
    if (anyMatch)     writeIdx = matchIdx;
    else if (anyFree) writeIdx = freeIdx;
    else              writeIdx = rrPtr;
  end

  always_comb begin
    strobe.flushAll  = flushAll;
    strobe.flushAsid = flushAsidValid;
    strobe.write     = refillValid && !flushAll && !flushAsidValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.write && useRr) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  // Lookup classification, registered for one cycle of latency.
  always_comb begin
    faultNow = lkValid && ({1'b0, lkVpn} >= tableLen);
    hitNow   = lkValid && !faultNow && (|hitVec);
    missNow  = lkValid && !faultNow && !(|hitVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspFault <= 1'b0;
      rspPaddr <= '0;
      walkReq  <= 1'b0;
      walkVpn  <= '0;
      walkAsid <= '0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= hitNow;
      rspMiss  <= missNow;
      rspFault <= faultNow;
      rspPaddr <= hitNow ? {hitPfn, lkOffset} : '0;
      walkReq  <= missNow;
      walkVpn  <= missNow ? lkVpn : '0;
      walkAsid <= missNow ? lkAsid : '0;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W:0]    tableLen,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              walkReq,
  output logic [VPN_W-1:0]  walkVpn,
  output logic [ASID_W-1:0] walkAsid,
  input  logic              refillValid,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [ASID_W-1:0] refillAsid,
  input  logic [PFN_W-1:0]  refillPfn,
  input  logic              flushAll,
  input  logic              flushAsidValid,
  input  logic [ASID_W-1:0] flushAsid
);
  tlbStrobe_t         strobe;
  logic [IDX_W-1:0]   writeIdx;
  logic [ENTRIES-1:0] validVec, hitVec, refillHitVec;
  logic [PFN_W-1:0]   hitPfn;

  tlb_datapath #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .writeIdx(writeIdx),
    .refillVpn(refillVpn), .refillAsid(refillAsid), .refillPfn(refillPfn),
    .flushTag(flushAsid), .lookVpn(lkVaddr[VA_W-1:OFF_W]), .lookAsid(lkAsid),
    .validVec(validVec), .hitVec(hitVec), .refillHitVec(refillHitVec), .hitPfn(hitPfn)
  );

  tlb_ctrl #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .OFF_W(OFF_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVaddr[VA_W-1:OFF_W]),
    .lkAsid(lkAsid), .lkOffset(lkVaddr[OFF_W-1:0]), .tableLen(tableLen),
    .refillValid(refillValid), .flushAll(flushAll), .flushAsidValid(flushAsidValid),
    .validVec(validVec), .hitVec(hitVec), .refillHitVec(refillHitVec), .hitPfn(hitPfn),
    .strobe(strobe), .writeIdx(writeIdx), .rspValid(rspValid), .rspHit(rspHit),
    .rspMiss(rspMiss), .rspFault(rspFault), .rspPaddr(rspPaddr), .walkReq(walkReq),
    .walkVpn(walkVpn), .walkAsid(walkAsid)
  );
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PFN_W + OFF_W
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic [VA_W-1:0] lkVaddr,
  input logic [VPN_W:0]  tableLen,
  input logic            rspValid,
  input logic            rspHit,
  input logic            rspMiss,
  input logic            rspFault,
  input logic [PA_W-1:0] rspPaddr,
  input logic            walkReq,
  input logic            flushAll
);
  p_resp_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  p_resp_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);
  p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones({rspHit, rspMiss, rspFault}) == 1));
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (!rspHit || (rspPaddr[OFF_W-1:0] == $past(lkVaddr[OFF_W-1:0]))));
  p_fault_no_walk_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && ({1'b0, lkVaddr[VA_W-1:OFF_W]} >= tableLen)) |=> (rspFault && !walkReq));
  p_walk_on_miss_r5: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> (rspValid && rspMiss));
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushAll ##1 lkValid |=> !rspHit);
endmodule

bind asid_tlb asid_tlb_chk #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr), .tableLen(tableLen),
  .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault),
  .rspPaddr(rspPaddr), .walkReq(walkReq), .flushAll(flushAll)
);

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
  localparam int VPN_W = 20, ASID_W = 8, OFF_W = 12, PFN_W = 20;
  localparam int VA_W = VPN_W + OFF_W, PA_W = PFN_W + OFF_W;
  localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2;
  localparam logic [ASID_W-1:0] TA = 8'h11, TB = 8'h22;

  logic clk = 1'b0, rstN = 1'b0;
  logic lkValid = 1'b0;
  logic [VA_W-1:0] lkVaddr = '0;
  logic [ASID_W-1:0] lkAsid = '0;
  logic [VPN_W:0] tableLen = 21'h1000;
  logic rspValid, rspHit, rspMiss, rspFault, walkReq;
  logic [PA_W-1:0] rspPaddr;
  logic [VPN_W-1:0] walkVpn;
  logic [ASID_W-1:0] walkAsid;
  logic refillValid = 1'b0;
  logic [VPN_W-1:0] refillVpn = '0;
  logic [ASID_W-1:0] refillAsid = '0;
  logic [PFN_W-1:0] refillPfn = '0;
  logic flushAll = 1'b0, flushAsidValid = 1'b0;
  logic [ASID_W-1:0] flushAsid = '0;

  always #2.5 clk = ~clk;

  asid_tlb dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr), .lkAsid(lkAsid),
    .tableLen(tableLen), .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspFault(rspFault), .rspPaddr(rspPaddr), .walkReq(walkReq), .walkVpn(walkVpn),
    .walkAsid(walkAsid), .refillValid(refillValid), .refillVpn(refillVpn),
    .refillAsid(refillAsid), .refillPfn(refillPfn), .flushAll(flushAll),
    .flushAsidValid(flushAsidValid), .flushAsid(flushAsid)
  );

  typedef struct {
    int               kind;
    logic [PA_W-1:0]  paddr;
    logic [VPN_W-1:0] vpn;
    logic [ASID_W-1:0] asid;
    string            req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver tasks: set inputs right after a falling edge; tick() ends the cycle.
  task automatic lookup(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid,
                        logic [OFF_W-1:0] off, int kind, logic [PFN_W-1:0] pfn, string req);
    expItem_t e;
    e.kind = kind;
    e.paddr = (kind == K_HIT) ? {pfn, off} : '0;
    e.vpn = vpn; e.asid = asid; e.req = req;
    expQ.push_back(e);
    lkValid = 1'b1; lkVaddr = {vpn, off}; lkAsid = asid;
  endtask

  task automatic refill(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid, logic [PFN_W-1:0] pfn);
    refillValid = 1'b1; refillVpn = vpn; refillAsid = asid; refillPfn = pfn;
  endtask

  task automatic tick();
    @(negedge clk);
    lkValid = 1'b0; refillValid = 1'b0; flushAll = 1'b0; flushAsidValid = 1'b0;
  endtask

  // Monitor: compare each response against the scoreboard head.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        chk("R1", "unexpected response", 64'(1), 64'(0));
      end else begin
        expItem_t e;
        int actKind;
        e = expQ.pop_front();
        actKind = rspHit ? K_HIT : rspMiss ? K_MISS : rspFault ? K_FAULT : 3;
        chk(e.req, "outcome", 64'(actKind), 64'(e.kind));
        chk(e.req, "paddr", 64'(rspPaddr), 64'(e.paddr));
        chk(e.req, "walkReq", 64'(walkReq), 64'(e.kind == K_MISS));
        if (e.kind == K_MISS) begin
          chk(e.req, "walkVpn", 64'(walkVpn), 64'(e.vpn));
          chk(e.req, "walkAsid", 64'(walkAsid), 64'(e.asid));
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk("R13", "rspValid after reset", 64'(rspValid), 64'(0));
    chk("R13", "walkReq after reset", 64'(walkReq), 64'(0));
    lookup(20'd5, TA, 12'h001, K_MISS, '0, "R13"); tick();
    // R1: idle cycle gives no response
    tick();
    chk("R1", "idle rspValid", 64'(rspValid), 64'(0));
    // R4: fault at the length boundary, legal one below
    lookup(20'h01000, TA, 12'h0, K_FAULT, '0, "R4"); tick();
    lookup(20'h00FFF, TA, 12'h0, K_MISS, '0, "R5"); tick();
    // R2, R6: install and hit
    refill(20'd5, TA, 20'hABCDE); tick();
    lookup(20'd5, TA, 12'h123, K_HIT, 20'hABCDE, "R2"); tick();
    // R3: same page, other tag
    lookup(20'd5, TB, 12'h010, K_MISS, '0, "R3"); tick();
    refill(20'd5, TB, 20'h11111); tick();
    lookup(20'd5, TB, 12'h010, K_HIT, 20'h11111, "R3"); tick();
    lookup(20'd5, TA, 12'hFFF, K_HIT, 20'hABCDE, "R3"); tick();
    // R4: fault wins over a cached mapping
    tableLen = 21'd5;
    lookup(20'd5, TA, 12'h0, K_FAULT, '0, "R4"); tick();
    tableLen = 21'h1000;
    // R6: lookup in the refill cycle sees old contents
    refill(20'd7, TA, 20'h00777);
    lookup(20'd7, TA, 12'h044, K_MISS, '0, "R6"); tick();
    lookup(20'd7, TA, 12'h044, K_HIT, 20'h00777, "R6"); tick();
    // Entries: 0:(5,A) 1:(5,B) 2:(7,A). R9: overwrite in place.
    refill(20'd5, TA, 20'h22222); tick();
    lookup(20'd5, TA, 12'h0, K_HIT, 20'h22222, "R9"); tick();
    // R11: flush tag B only
    flushAsidValid = 1'b1; flushAsid = TB; tick();
    lookup(20'd5, TB, 12'h0, K_MISS, '0, "R11"); tick();
    lookup(20'd5, TA, 12'h0, K_HIT, 20'h22222, "R11"); tick();
    lookup(20'd7, TA, 12'h0, K_HIT, 20'h00777, "R11"); tick();
    // R7: new entry fills the hole at index 1, then indexes 3..7
    refill(20'd9, TB, 20'h00099); tick();
    for (int i = 0; i < 5; i++) begin
      refill(20'(20 + i), TA, 20'(32 + i)); tick();
    end
    // R8: full; first eviction hits index 0 (5,A)
    refill(20'd30, TA, 20'h00030); tick();
    lookup(20'd5, TA, 12'h0, K_MISS, '0, "R8"); tick();
    lookup(20'd9, TB, 12'h0, K_HIT, 20'h00099, "R7"); tick();
    lookup(20'd30, TA, 12'h0, K_HIT, 20'h00030, "R8"); tick();
    // R8: next eviction hits index 1 (9,B)
    refill(20'd31, TA, 20'h00031); tick();
    lookup(20'd9, TB, 12'h0, K_MISS, '0, "R7"); tick();
    lookup(20'd7, TA, 12'h0, K_HIT, 20'h00777, "R8"); tick();
    lookup(20'd24, TA, 12'h0, K_HIT, 20'd36, "R9"); tick();
    // R12, R10: global flush discards a concurrent refill
    flushAll = 1'b1; refill(20'd40, TA, 20'h00040); tick();
    lookup(20'd40, TA, 12'h0, K_MISS, '0, "R12"); tick();
    lookup(20'd7, TA, 12'h0, K_MISS, '0, "R10"); tick();
    lookup(20'd31, TA, 12'h0, K_MISS, '0, "R10"); tick();
    refill(20'd41, TA, 20'h00041); tick();
    lookup(20'd41, TA, 12'h0, K_HIT, 20'h00041, "R6"); tick();
    // R12: tag flush discards a concurrent refill
    flushAsidValid = 1'b1; flushAsid = TA; refill(20'd42, TB, 20'h00042); tick();
    lookup(20'd42, TB, 12'h0, K_MISS, '0, "R12"); tick();
    lookup(20'd41, TA, 12'h0, K_MISS, '0, "R11"); tick();
    tick(); tick();
    chk("R1", "pending responses", 64'(expQ.size()), 64'(0));
    finish();
  end
endmodule